// File: doc/BRIEF.md
# Audio Port Interrupt and Frame-Match Controller

This block keeps the interrupt state of a serial audio port. Eight interrupt sources each own a pair of bits in one 32-bit register: an enable bit and, directly below it, a pending bit. The pairs fill the upper half of the word. Seven of the sources are external events that arrive as single-cycle pulses. The eighth is internal: a 32-bit frame counter compared with a programmable match value.

Software uses a simple register port. It reads and writes the interrupt register, loads the frame counter, and sets the match value. Pending flags are cleared by writing a one to them. The block drives a single level interrupt line. That line is high whenever any source has both its enable bit and its pending bit set.

The external reset is asynchronous and active low. Inside the block it is released synchronously, two clock edges after `rst_n` rises.

Top module: `audio_irq_ctl`

## Requirements
- R1: Registers are decoded from the full byte address. The interrupt register is at 0x00, the frame counter at 0x40 and the match value at 0x50. Any other address reads as zero, and a write to it changes no register.
- R2: Source k (0..7) has its enable bit at position 31-2k and its pending bit at 30-2k. The source order is: frame match, message, new peak, clocks stopped, sync error, sync ok, new sample rate, status. Input `evt_i[i]` drives source i+1.
- R3: Bits 15..0 of the interrupt register read as zero, and writes to them have no effect.
- R4: An event pulse sets its pending bit one cycle later, whether or not the enable bit is set.
- R5: A write to the interrupt register loads all enable bits from the write data. A 1 in a pending bit position clears that flag. A 0 leaves the flag unchanged.
- R6: If an event arrives in the same cycle that its pending bit is written with 1, the bit stays set.
- R7: `irq_o` equals the OR over all sources of (enable AND pending). It follows the register state in the same cycle that the state becomes readable.
- R8: The frame counter is 32 bits wide. It adds one on each `frame_tick_i` and wraps from 0xFFFFFFFF to 0. A write to 0x40 loads the counter, and it takes priority over a tick in the same cycle.
- R9: The frame-match pending bit is set when an increment produces a value equal to the match register. Loading the counter, or holding a count equal to the match value without ticking, does not set it.
- R10: After reset, every register reads zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 8 | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| frame_tick_i | input | 1 | One-cycle pulse per audio frame |
| evt_i | input | 7 | Event pulses for sources 1..7 |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two things can hit the same pending bit in a single cycle: an arriving event, and a software write-one-to-clear. The same is true for the frame source, where a counter tick that reaches the match value can coincide with a clear of the frame-match flag. The bench drives each source's pulse, or the matching tick, in the same cycle as the clearing write. It then expects the flag to read back as set and `irq_o` to follow the enable bit. A second collision is a counter load in the same cycle as a tick. There, the loaded value must be read back and no match must be raised.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

  // Source index; position in the interrupt register follows from it.
  typedef enum logic [2:0] {
    SRC_FRAME   = 3'd0,
    SRC_MSG     = 3'd1,
    SRC_PEAK    = 3'd2,
    SRC_CLKSTOP = 3'd3,
    SRC_SYNCERR = 3'd4,
    SRC_SYNCOK  = 3'd5,
    SRC_RATE    = 3'd6,
    SRC_STATUS  = 3'd7
  } irq_src_e;

  // Register offsets (byte addresses)
  localparam logic [7:0] OFS_INTR   = 8'h00;
  localparam logic [7:0] OFS_FCOUNT = 8'h40;
  localparam logic [7:0] OFS_FMATCH = 8'h50;

  typedef struct packed {
    logic intr;
    logic fcount;
    logic fmatch;
  } reg_sel_t;

endpackage

// File: rtl/audio_rst_sync.sv
module audio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/audio_irq_flag.sv
module audio_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic en_wdata_i,
  input  logic clr_wdata_i,
  input  logic set_i,
  output logic en_o,
  output logic pend_o
);

  logic en_q;
  logic en_d;
  logic pend_q;
  logic pend_d;
  logic clr;

  assign clr = wr_i & clr_wdata_i;

  always_comb begin
    en_d = en_q;
    if (wr_i) begin
      en_d = en_wdata_i;
    end
    pend_d = pend_q;
    if (clr) begin
      pend_d = 1'b0;
    end
    if (set_i) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;

  // R4 R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);

  // R5
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && clr_wdata_i && !set_i) |=> !pend_q);

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> !$rose(pend_q));

  // R5
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_q == $past(en_wdata_i)));

endmodule

// File: rtl/audio_frame_match.sv
module audio_frame_match #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic             match_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] match_o,
  output logic             hit_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_en;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] match_d;
  logic             match_en;

  assign cnt_inc  = cnt_q + CNT_ONE;
  assign cnt_en   = cnt_we_i | tick_i;
  assign match_en = match_we_i;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_we_i) begin
      cnt_d = wdata_i;
    end else if (tick_i) begin
      cnt_d = cnt_inc;
    end
    match_d = match_q;
    if (match_we_i) begin
      match_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (match_en) begin
      match_q <= match_d;
    end
  end

  // Compare the value being produced by this increment.
  assign hit_o   = tick_i & ~cnt_we_i & (cnt_inc == match_q);
  assign cnt_o   = cnt_q;
  assign match_o = match_q;

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_we_i) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R8
  load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> (cnt_q == $past(wdata_i)));

  // R9
  hit_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !match_we_i) |=> (cnt_q == match_q));

  // R9
  hit_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |-> !hit_o);

endmodule

// File: rtl/audio_reg_decode.sv
module audio_reg_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              [ADDR_W-1:0] addr_i,
  input  logic                           we_i,
  input  logic              [DATA_W-1:0] intr_rd_i,
  input  logic              [DATA_W-1:0] cnt_rd_i,
  input  logic              [DATA_W-1:0] match_rd_i,
  output audio_irq_pkg::reg_sel_t        wr_sel_o,
  output logic              [DATA_W-1:0] rdata_o
);

  import audio_irq_pkg::*;

  reg_sel_t sel;

  always_comb begin
    sel.intr   = (addr_i == ADDR_W'(OFS_INTR));
    sel.fcount = (addr_i == ADDR_W'(OFS_FCOUNT));
    sel.fmatch = (addr_i == ADDR_W'(OFS_FMATCH));
  end

  always_comb begin
    wr_sel_o.intr   = we_i & sel.intr;
    wr_sel_o.fcount = we_i & sel.fcount;
    wr_sel_o.fmatch = we_i & sel.fmatch;
  end

  always_comb begin
    rdata_o = '0;
    if (sel.intr) begin
      rdata_o = intr_rd_i;
    end else if (sel.fcount) begin
      rdata_o = cnt_rd_i;
    end else if (sel.fmatch) begin
      rdata_o = match_rd_i;
    end
  end

endmodule

// File: rtl/audio_irq_ctl.sv
module audio_irq_ctl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NSRC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              frame_tick_i,
  input  logic [NSRC-2:0]   evt_i,
  output logic              irq_o
);

  import audio_irq_pkg::*;

  localparam int unsigned NEVT  = NSRC - 1;
  localparam int unsigned LOW_W = DATA_W - 2 * NSRC;

  logic              rst_int_n;
  reg_sel_t          wr_sel;
  logic [DATA_W-1:0] intr_word;
  logic [DATA_W-1:0] cnt_val;
  logic [DATA_W-1:0] match_val;
  logic              frame_hit;
  logic [NSRC-1:0]   src_vec;
  logic [NSRC-1:0]   en_vec;
  logic [NSRC-1:0]   pend_vec;

  audio_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  audio_reg_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_decode (
    .addr_i     (reg_addr_i),
    .we_i       (reg_we_i),
    .intr_rd_i  (intr_word),
    .cnt_rd_i   (cnt_val),
    .match_rd_i (match_val),
    .wr_sel_o   (wr_sel),
    .rdata_o    (reg_rdata_o)
  );

  audio_frame_match #(
    .CNT_W (DATA_W)
  ) i_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (frame_tick_i),
    .cnt_we_i   (wr_sel.fcount),
    .match_we_i (wr_sel.fmatch),
    .wdata_i    (reg_wdata_i),
    .cnt_o      (cnt_val),
    .match_o    (match_val),
    .hit_o      (frame_hit)
  );

  // Source 0 is the frame comparator, the rest are external pulses.
  assign src_vec[SRC_FRAME]  = frame_hit;
  assign src_vec[NSRC-1:1]   = evt_i[NEVT-1:0];

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam int unsigned EN_BIT = DATA_W - 1 - 2 * k;
    localparam int unsigned PD_BIT = DATA_W - 2 - 2 * k;

    audio_irq_flag i_flag (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .wr_i        (wr_sel.intr),
      .en_wdata_i  (reg_wdata_i[EN_BIT]),
      .clr_wdata_i (reg_wdata_i[PD_BIT]),
      .set_i       (src_vec[k]),
      .en_o        (en_vec[k]),
      .pend_o      (pend_vec[k])
    );

    assign intr_word[EN_BIT] = en_vec[k];
    assign intr_word[PD_BIT] = pend_vec[k];
  end

  assign intr_word[LOW_W-1:0] = '0;

  assign irq_o = |(en_vec & pend_vec);

  // R3
  low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_addr_i == ADDR_W'(OFS_INTR)) |-> (reg_rdata_o[LOW_W-1:0] == '0));

  // R7
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_o && reg_addr_i == ADDR_W'(OFS_INTR)) |-> (reg_rdata_o != '0));

endmodule

// File: tb/test_audio_irq_ctl.sv
`timescale 1ns/1ps
module test_audio_irq_ctl;

  logic        clk;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        frame_tick;
  logic [6:0]  evt;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference state
  logic [7:0]  m_en;
  logic [7:0]  m_pend;
  logic [31:0] m_cnt;
  logic [31:0] m_match;

  audio_irq_ctl i_audio_irq_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr_i   (reg_addr),
    .reg_we_i     (reg_we),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .frame_tick_i (frame_tick),
    .evt_i        (evt),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] pack(input logic [7:0] en, input logic [7:0] pd);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      w[31 - 2 * k] = en[k];
      w[30 - 2 * k] = pd[k];
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    reg_addr = 8'h00; #1;
    check({tag, " R2 interrupt register"}, reg_rdata, pack(m_en, m_pend));
    reg_addr = 8'h40; #1;
    check({tag, " R8 frame counter"}, reg_rdata, m_cnt);
    reg_addr = 8'h50; #1;
    check({tag, " R9 match register"}, reg_rdata, m_match);
    reg_addr = 8'h20; #1;
    check({tag, " R1 unmapped read"}, reg_rdata, 32'h0);
    check({tag, " R7 irq level"}, {31'h0, irq}, {31'h0, |(m_en & m_pend)});
  endtask

  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input logic [6:0] ev, input bit tk);
    logic        cnt_wr, match_wr, intr_wr, hit;
    logic [7:0]  en_w, clr_w, src;
    reg_we = we; reg_addr = a; reg_wdata = d; evt = ev; frame_tick = tk;
    cnt_wr   = we && a == 8'h40;
    match_wr = we && a == 8'h50;
    intr_wr  = we && a == 8'h00;
    hit      = tk && !cnt_wr && ((m_cnt + 32'd1) == m_match);
    for (int k = 0; k < 8; k++) begin
      en_w[k]  = d[31 - 2 * k];
      clr_w[k] = d[30 - 2 * k];
    end
    src = {ev, hit};
    @(posedge clk);
    m_pend  = (m_pend & ~(intr_wr ? clr_w : 8'h00)) | src;
    if (intr_wr) m_en = en_w;
    if (cnt_wr) m_cnt = d; else if (tk) m_cnt = m_cnt + 32'd1;
    if (match_wr) m_match = d;
    #1;
    reg_we = 1'b0; evt = '0; frame_tick = 1'b0; reg_wdata = '0;
  endtask

  task automatic idle();
    step(0, 8'h00, 32'h0, 7'h0, 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    frame_tick = 1'b0; evt = '0;
    m_en = '0; m_pend = '0; m_cnt = '0; m_match = '0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R10 in reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_all("R10 after reset");

    // R4 R2 R5: each external source, enable off and on
    for (int k = 1; k < 8; k++) begin
      for (int e = 0; e < 2; e++) begin
        logic [7:0] en = 8'h00;
        en[k] = e[0];
        step(1, 8'h00, pack(en, 8'h00), 7'h0, 0);
        check_all("R5 enable load");
        step(0, 8'h00, 32'h0, 7'(1 << (k - 1)), 0);
        check_all("R4 event sets pending");
        step(1, 8'h00, pack(en, 8'(1 << k)), 7'h0, 0);
        check_all("R5 write one clears");
      end
    end

    // R3: low half ignores writes; all enables set, all pendings cleared
    step(0, 8'h00, 32'h0, 7'h7F, 0);
    step(1, 8'h00, 32'hFFFF_FFFF, 7'h0, 0);
    check_all("R3 low half and R5 clear all");

    // R5: writing 0 to pending bits leaves them
    step(0, 8'h00, 32'h0, 7'h55, 0);
    step(1, 8'h00, pack(8'hA5, 8'h00), 7'h0, 0);
    check_all("R5 zero keeps pending");

    // R6: event and clear in the same cycle
    for (int k = 1; k < 8; k++) begin
      step(1, 8'h00, pack(8'hFF, 8'hFF), 7'h0, 0);
      step(1, 8'h00, pack(8'hFF, 8'(1 << k)), 7'(1 << (k - 1)), 0);
      check_all("R6 event beats clear");
    end
    step(1, 8'h00, pack(8'h01, 8'hFF), 7'h0, 0);

    // R1: unmapped writes leave all registers untouched
    step(1, 8'h10, 32'hFFFF_FFFF, 7'h0, 0);
    step(1, 8'h44, 32'hFFFF_FFFF, 7'h0, 0);
    step(1, 8'hFC, 32'hFFFF_FFFF, 7'h0, 0);
    step(1, 8'h01, 32'hFFFF_FFFF, 7'h0, 0);
    check_all("R1 unmapped writes ignored");

    // R9 R8: sweep of match distances
    for (int m = 1; m <= 16; m++) begin
      step(1, 8'h40, 32'h0, 7'h0, 0);
      step(1, 8'h50, 32'(m), 7'h0, 0);
      step(1, 8'h00, pack(8'h01, 8'hFF), 7'h0, 0);
      check_all("R9 setup");
      for (int t = 0; t < m + 2; t++) begin
        step(0, 8'h00, 32'h0, 7'h0, 1);
        check_all("R9 R8 tick sweep");
      end
    end

    // R9: loading count equal to match does not raise
    step(1, 8'h00, pack(8'h01, 8'hFF), 7'h0, 0);
    step(1, 8'h50, 32'h0000_1234, 7'h0, 0);
    step(1, 8'h40, 32'h0000_1234, 7'h0, 0);
    idle();
    idle();
    check_all("R9 load equal no hit");

    // R8: load has priority over tick; no hit from the load
    step(1, 8'h40, 32'h0000_1233, 7'h0, 0);
    step(1, 8'h40, 32'h0000_1233, 7'h0, 1);
    check_all("R8 load beats tick");
    step(0, 8'h00, 32'h0, 7'h0, 1);
    check_all("R9 hit after load");

    // R6: frame hit together with a clear of its flag
    step(1, 8'h40, 32'h0000_1233, 7'h0, 0);
    step(1, 8'h00, pack(8'h01, 8'h01), 7'h0, 1);
    check_all("R6 frame hit beats clear");

    // R8 R9: wrap to zero matches 0
    step(1, 8'h00, pack(8'h01, 8'hFF), 7'h0, 0);
    step(1, 8'h50, 32'h0, 7'h0, 0);
    step(1, 8'h40, 32'hFFFF_FFFE, 7'h0, 0);
    step(0, 8'h00, 32'h0, 7'h0, 1);
    check_all("R8 near wrap");
    step(0, 8'h00, 32'h0, 7'h0, 1);
    check_all("R8 wrap R9 match at zero");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule